// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block watches a software heartbeat line and drives an active-low fault output when the heartbeat stops for too long. Every level change on the heartbeat counts as a service event, whether the line rises or falls. The input is brought into the clock domain through a synchroniser chain, and each change becomes a one-cycle kick.

The timer has two timeout lengths. A long initial window applies after block reset, while the system reset is asserted, while the watchdog is strapped off, and after every expiry. This gives boot code time to start servicing. The first kick switches the timer to the short normal window, and each later kick restarts that window. When a window runs out, the fault output goes low for a fixed pulse of a few cycles. A system reset seen during that pulse ends it early.

A disable strap turns the watchdog off completely. A low hold input freezes the timer and the fault output at their current values, which allows supply margining without false faults.

Top module: `wdt_dual_mode`

## Requirements
- R1: After block reset (`rst` high, synchronous), `wdt_fault_n` is 1, the timer is in initial mode and the count is zero.
- R2: A rising or a falling edge on `wd_kick_i` is one kick. It passes through a two-flop synchroniser and reaches the timer on the third rising clock edge after the input changes.
- R3: In initial mode with no kick, `wdt_fault_n` goes to 0 on the INIT_MULT*NORMAL_CYCLES-th clock edge after counting starts. Counting starts on the first edge after block reset, system reset, strap-off or fault release.
- R4: A kick switches the timer to normal mode and clears the count. With no further kick, `wdt_fault_n` falls NORMAL_CYCLES edges after the kick, which is NORMAL_CYCLES+3 edges after the input change.
- R5: On expiry, `wdt_fault_n` stays 0 for exactly PULSE_CYCLES cycles and then returns to 1. The timer is then in initial mode with a cleared count.
- R6: Kicks that arrive while `wdt_fault_n` is 0 are ignored, so the window after release is the initial one.
- R7: While `sys_rst_i` is 1 and `hold_n_i` is 1, the count is held at zero, the mode is initial, and `wdt_fault_n` is 1 from the next edge onward. This also ends a fault pulse early.
- R8: While `wd_off_i` is 1, `wdt_fault_n` is 1 from the next edge onward and the timer is cleared to initial mode. The strap overrides every other input except `rst`.
- R9: While `hold_n_i` is 0 and the strap is off, `wdt_fault_n`, the count, the mode and the pulse length are frozen. Kicks and `sys_rst_i` have no effect during that time.
- R10: Kicks spaced fewer than NORMAL_CYCLES edges apart keep `wdt_fault_n` at 1 indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| sys_rst_i | input | 1 | System reset level, active high; clears the timer |
| hold_n_i | input | 1 | Margin hold, active low; freezes the timer and the fault output |
| wd_off_i | input | 1 | Disable strap, active high |
| wd_kick_i | input | 1 | Asynchronous heartbeat input; every edge is a kick |
| wdt_fault_n | output | 1 | Active-low watchdog fault |

## Verification
Several properties are checked on every cycle: the strap releases the fault output on the next edge; a hold freezes both the output and the count; a system reset clears the timer; a kick lands in normal mode with a zero count; an expiry drives the output low; and the count and the pulse counter stay within their limits. Other behaviour only shows up over whole scenarios. These are the exact window lengths in both modes, the synchroniser latency, the pulse width, the window restart after release, a kick being lost during a pulse, and a frozen pulse resuming where it stopped. The bench measures these against a cycle model while directed and seeded random traffic on all inputs runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        WD_INITIAL = 1'b0,
        WD_NORMAL  = 1'b1
    } wd_mode_e;

    // Control inputs common to the timer and the fault stage.
    typedef struct packed {
        logic off;
        logic hold_n;
        logic sys_rst;
    } wd_ctrl_t;

    function automatic int unsigned wd_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic kick_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b0;
        else     chain_q[0] <= async_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= 1'b0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign kick_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int unsigned NORMAL_CYCLES = 100,
    parameter int unsigned INIT_CYCLES   = 6400,
    parameter int unsigned CNT_W         = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  wd_ctrl_t         ctrl,
    input  logic             fault_active,
    input  logic             kick,
    output logic [CNT_W-1:0] cnt,
    output wd_mode_e         mode,
    output logic             expire
);
    typedef struct packed {
        wd_mode_e         mode;
        logic [CNT_W-1:0] cnt;
    } tstate_t;

    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORMAL_CYCLES - 1);

    tstate_t          st_q;
    logic [CNT_W-1:0] last;
    logic             run;

    assign last   = (st_q.mode == WD_INITIAL) ? INIT_LAST : NORM_LAST;
    assign run    = !ctrl.off && ctrl.hold_n && !ctrl.sys_rst && !fault_active;
    assign expire = run && !kick && (st_q.cnt == last);

    always_ff @(posedge clk) begin
        if (rst || ctrl.off) begin
            st_q <= '{mode: WD_INITIAL, cnt: '0};
        end else if (!ctrl.hold_n) begin
            st_q <= st_q;
        end else if (ctrl.sys_rst || fault_active) begin
            st_q <= '{mode: WD_INITIAL, cnt: '0};
        end else if (kick) begin
            st_q <= '{mode: WD_NORMAL, cnt: '0};
        end else if (expire) begin
            st_q <= '{mode: WD_INITIAL, cnt: '0};
        end else begin
            st_q.cnt <= st_q.cnt + 1'b1;
        end
    end

    assign cnt  = st_q.cnt;
    assign mode = st_q.mode;

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= last);
endmodule

// File: rtl/wdt_fault_stage.sv
module wdt_fault_stage
    import wdt_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  wd_ctrl_t ctrl,
    input  logic     expire,
    output logic     fault_active
);
    localparam int unsigned PW = wd_width(PULSE_CYCLES);
    localparam logic [PW-1:0] PLAST = PW'(PULSE_CYCLES - 1);

    logic          fault_q;
    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst || ctrl.off) begin
            fault_q <= 1'b0;
            pcnt_q  <= '0;
        end else if (!ctrl.hold_n) begin
            fault_q <= fault_q;
            pcnt_q  <= pcnt_q;
        end else if (ctrl.sys_rst) begin
            fault_q <= 1'b0;
            pcnt_q  <= '0;
        end else if (fault_q) begin
            if (pcnt_q == PLAST) begin
                fault_q <= 1'b0;
                pcnt_q  <= '0;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end else if (expire) begin
            fault_q <= 1'b1;
            pcnt_q  <= '0;
        end
    end

    assign fault_active = fault_q;

    p_pulse_range_r5: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= PLAST);
    p_idle_pcnt_r5: assert property (@(posedge clk) disable iff (rst)
        !fault_q |-> pcnt_q == '0);
endmodule

// File: rtl/wdt_dual_mode.sv
module wdt_dual_mode
    import wdt_pkg::*;
#(
    parameter int unsigned NORMAL_CYCLES = 100,
    parameter int unsigned INIT_MULT     = 64,
    parameter int unsigned PULSE_CYCLES  = 4,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_rst_i,
    input  logic hold_n_i,
    input  logic wd_off_i,
    input  logic wd_kick_i,
    output logic wdt_fault_n
);
    localparam int unsigned INIT_CYCLES = NORMAL_CYCLES * INIT_MULT;
    localparam int unsigned CNT_W       = wd_width(INIT_CYCLES);

    wd_ctrl_t         ctrl;
    logic             kick;
    logic             expire;
    logic             fault_active;
    logic [CNT_W-1:0] cnt;
    wd_mode_e         mode;

    assign ctrl = '{off: wd_off_i, hold_n: hold_n_i, sys_rst: sys_rst_i};

    wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (wd_kick_i),
        .kick_o  (kick)
    );

    wdt_timer #(
        .NORMAL_CYCLES (NORMAL_CYCLES),
        .INIT_CYCLES   (INIT_CYCLES),
        .CNT_W         (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl),
        .fault_active (fault_active),
        .kick         (kick),
        .cnt          (cnt),
        .mode         (mode),
        .expire       (expire)
    );

    wdt_fault_stage #(.PULSE_CYCLES(PULSE_CYCLES)) u_fault (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl),
        .expire       (expire),
        .fault_active (fault_active)
    );

    assign wdt_fault_n = !fault_active;

    p_off_release_r8: assert property (@(posedge clk) disable iff (rst)
        wd_off_i |=> wdt_fault_n && cnt == '0 && mode == WD_INITIAL);
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (!wd_off_i && !hold_n_i) |=> $stable(wdt_fault_n) && $stable(cnt) && $stable(mode));
    p_sys_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_i && hold_n_i && !wd_off_i) |=> wdt_fault_n && cnt == '0 && mode == WD_INITIAL);
    p_kick_normal_r4: assert property (@(posedge clk) disable iff (rst)
        (kick && hold_n_i && !wd_off_i && !sys_rst_i && !fault_active) |=> mode == WD_NORMAL && cnt == '0);
    p_expire_fault_r3: assert property (@(posedge clk) disable iff (rst)
        expire |=> !wdt_fault_n);
    p_fault_idle_r6: assert property (@(posedge clk) disable iff (rst)
        fault_active |-> cnt == '0 && mode == WD_INITIAL);
endmodule

// File: tb/wdt_dual_mode_tb.sv
module wdt_dual_mode_tb;
    localparam int NORM  = 20;
    localparam int MULT  = 64;
    localparam int INIT  = NORM * MULT;
    localparam int PULSE = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sys_rst_i = 1'b0;
    logic hold_n_i = 1'b1;
    logic wd_off_i = 1'b0;
    logic wd_kick_i = 1'b0;
    logic wdt_fault_n;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    string phase = "R1";

    // Reference model state
    int m_cnt = 0, m_pc = 0;
    bit m_norm = 0, m_fault = 0;
    bit m_s1 = 0, m_s2 = 0, m_s3 = 0;

    always #10 clk = ~clk;

    wdt_dual_mode #(
        .NORMAL_CYCLES (NORM),
        .INIT_MULT     (MULT),
        .PULSE_CYCLES  (PULSE),
        .SYNC_STAGES   (2)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .sys_rst_i   (sys_rst_i),
        .hold_n_i    (hold_n_i),
        .wd_off_i    (wd_off_i),
        .wd_kick_i   (wd_kick_i),
        .wdt_fault_n (wdt_fault_n)
    );

    function automatic int lim_of(bit norm);
        return norm ? NORM : INIT;
    endfunction

    always @(posedge clk) begin
        bit k;
        k = m_s2 ^ m_s3;
        if (rst) begin
            m_cnt = 0; m_pc = 0; m_norm = 0; m_fault = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            if (wd_off_i) begin
                m_cnt = 0; m_pc = 0; m_norm = 0; m_fault = 0;
            end else if (!hold_n_i) begin
            end else if (sys_rst_i) begin
                m_cnt = 0; m_pc = 0; m_norm = 0; m_fault = 0;
            end else if (m_fault) begin
                if (m_pc == PULSE - 1) begin m_fault = 0; m_pc = 0; end
                else m_pc++;
            end else if (k) begin
                m_cnt = 0; m_norm = 1;
            end else if (m_cnt == lim_of(m_norm) - 1) begin
                m_fault = 1; m_cnt = 0; m_norm = 0;
            end else begin
                m_cnt++;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = wd_kick_i;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on)
            check(wdt_fault_n === !m_fault, phase, int'(wdt_fault_n), int'(!m_fault));
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_low(input int maxn, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (wdt_fault_n !== 1'b0 && n < maxn);
    endtask

    task automatic low_width(output int w);
        w = 1;
        step();
        while (wdt_fault_n === 1'b0 && w < 10000) begin
            w++;
            step();
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: bench hung, actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, w;
        void'($urandom(32'h5eed_0042));
        repeat (5) @(negedge clk);
        check(wdt_fault_n === 1'b1, "R1 reset state", int'(wdt_fault_n), 1);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R3: initial window from reset, then R5 pulse width and return to initial
        phase = "R3";
        wait_low(5000, n);
        check(n == INIT, "R3 initial window", n, INIT);
        phase = "R5";
        low_width(w);
        check(w == PULSE, "R5 pulse width", w, PULSE);
        wait_low(5000, n);
        check(n == INIT, "R5 initial after expiry", n, INIT);

        // R6: kick during pulse is lost
        phase = "R6";
        wd_kick_i = ~wd_kick_i;
        low_width(w);
        check(w == PULSE, "R6 pulse unchanged", w, PULSE);
        wait_low(5000, n);
        check(n == INIT, "R6 kick ignored, initial window", n, INIT);
        low_width(w);

        // R2/R4: rising and falling edges each switch to normal
        phase = "R4";
        repeat (7) step();
        wd_kick_i = ~wd_kick_i;
        wait_low(5000, n);
        check(n == NORM + 3, "R4 normal window after edge", n, NORM + 3);
        low_width(w);
        repeat (3) step();
        wd_kick_i = ~wd_kick_i;
        wait_low(5000, n);
        check(n == NORM + 3, "R2 opposite polarity edge", n, NORM + 3);
        low_width(w);

        // R10: regular kicks keep output high
        phase = "R10";
        for (int i = 0; i < 30; i++) begin
            wd_kick_i = ~wd_kick_i;
            repeat (15) begin
                step();
                check(wdt_fault_n === 1'b1, "R10 serviced", int'(wdt_fault_n), 1);
            end
        end

        // R7: system reset ends a pulse and holds the timer cleared
        phase = "R7";
        wait_low(5000, n);
        sys_rst_i = 1'b1;
        step();
        check(wdt_fault_n === 1'b1, "R7 pulse cut by system reset", int'(wdt_fault_n), 1);
        repeat (2000) step();
        check(wdt_fault_n === 1'b1, "R7 no fault under system reset", int'(wdt_fault_n), 1);
        sys_rst_i = 1'b0;
        wait_low(5000, n);
        check(n == INIT, "R7 initial window after system reset", n, INIT);

        // R8: strap off
        phase = "R8";
        wd_off_i = 1'b1;
        step();
        check(wdt_fault_n === 1'b1, "R8 strap releases fault", int'(wdt_fault_n), 1);
        for (int i = 0; i < 3000; i++) begin
            if (i % 7 == 0) wd_kick_i = ~wd_kick_i;
            step();
        end
        check(wdt_fault_n === 1'b1, "R8 disabled stays high", int'(wdt_fault_n), 1);
        wd_off_i = 1'b0;
        repeat (4) step();
        wait_low(5000, n);
        check(n == INIT - 4, "R8 initial window after strap", n, INIT - 4);

        // R9: hold freezes the pulse
        phase = "R9";
        hold_n_i = 1'b0;
        sys_rst_i = 1'b1;
        repeat (50) step();
        check(wdt_fault_n === 1'b0, "R9 fault frozen low", int'(wdt_fault_n), 0);
        sys_rst_i = 1'b0;
        hold_n_i = 1'b1;
        low_width(w);
        check(w == PULSE, "R9 pulse resumes", w, PULSE);
        // hold freezes the count in normal mode
        wd_kick_i = ~wd_kick_i;
        repeat (10) step();
        hold_n_i = 1'b0;
        repeat (100) step();
        check(wdt_fault_n === 1'b1, "R9 frozen high", int'(wdt_fault_n), 1);
        hold_n_i = 1'b1;
        wait_low(5000, n);
        check(n == NORM + 3 - 10, "R9 count resumes", n, NORM + 3 - 10);
        low_width(w);

        // Random traffic against the model
        phase = "R2 random";
        for (int i = 0; i < 30000; i++) begin
            int r;
            r = int'($urandom_range(0, 999));
            if (r < 30) wd_kick_i = ~wd_kick_i;
            sys_rst_i = (r >= 990);
            hold_n_i  = !(r >= 975 && r < 985);
            wd_off_i  = (r == 500);
            step();
        end

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule